// File: doc/BRIEF.md
# Relay Byte-Command Address Decoder

This block takes byte-wide commands from a host link and decides, one command at a time, how each is served. A command has an 8-bit low address, a read/write flag and, for a write, one data byte. Writes aimed at four reserved low addresses never reach the bus. Three of them load the upper bytes of a 32-bit bus address, and the fourth is simply swallowed. While all upper bytes are zero, a few low addresses are served locally: an identity code, a hardware version, a firmware version and a test portal that yields a ramp.

Every other command goes to a single-byte bus cycle engine as a request. The request carries the stored upper bytes joined to the low address. The engine asserts `eng_done` when the cycle ends, and the block then returns the engine's read byte and bus-error flag to the host. Only 24-bit addressing is in use on the bus, so only the middle two upper bytes take part in selecting a slave. The top byte is still presented on `eng_addr`.

Top module: `relay_cmd_decoder`

## Requirements
- R1: An accepted write to low address 0x2A loads upper byte 3 (`eng_addr[31:24]`), 0x2B loads upper byte 2 (`eng_addr[23:16]`), and 0x2C loads upper byte 1 (`eng_addr[15:8]`). The response comes in the next cycle with `rsp_err` low, and no `eng_start` is produced.
- R2: An accepted write to low address 0x2D changes no upper byte and produces no `eng_start`. It is answered in the next cycle with `rsp_err` low. No bus write to a low byte in 0x2A..0x2D is ever requested.
- R3: When the three upper bytes are all zero, a read of low address 0x00 returns `HW_ID` (default 87), a read of 0x12 returns `HW_VER` (default 3) and a read of 0x13 returns `FW_VER` (default 4). Each is answered in the next cycle with `rsp_err` low and without `eng_start`.
- R4: When the upper bytes are zero, reads of low address 0x3F return 0 first after reset, then one more on each such read, wrapping from 255 to 0.
- R5: A forwarded command gives a one-cycle `eng_start` pulse in the cycle after acceptance. `eng_addr` equals {byte3, byte2, byte1, low address}, and `eng_write` and `eng_wdata` match the command.
- R6: If any upper byte is nonzero, reads of 0x00, 0x12, 0x13 and 0x3F are forwarded to the bus.
- R7: A read of any other low address is forwarded even when the upper bytes are zero.
- R8: `cmd_busy` is high from the cycle after a forwarded command is accepted until its response. Commands presented while busy are ignored.
- R9: In the cycle after `eng_done` while busy, `rsp_valid` pulses with `rsp_rdata` = `eng_rdata` and `rsp_err` = `eng_berr`, and `cmd_busy` drops.
- R10: Reset clears the upper bytes, the ramp, `cmd_busy`, `rsp_valid` and `eng_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Low byte of the address |
| cmd_wdata | input | 8 | Write data |
| cmd_busy | output | 1 | Bus request outstanding |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Read data of the response |
| rsp_err | output | 1 | Bus error on the response |
| eng_start | output | 1 | One-cycle request to the cycle engine |
| eng_write | output | 1 | Direction of the requested cycle |
| eng_addr | output | 32 | Full bus address of the request |
| eng_wdata | output | 8 | Write byte of the request |
| eng_done | input | 1 | Engine has finished the cycle |
| eng_rdata | input | 8 | Byte read by the engine |
| eng_berr | input | 1 | Engine saw a bus error |

## Verification
The bench checks that the zero-base test is made on all three upper bytes and not only on the two that select a slave. A design that ignored byte 3 would answer identity reads locally and lose them from the bus. The bench also runs the portal ramp through its wrap and writes to 0x2D to show nothing leaks onto the bus. It sends a base write while a request is outstanding, which a design with a missing busy gate would apply. It also drives a bus error, reset in mid-run, and unmapped reads at zero base, which a greedy local decode would answer itself.

// File: rtl/relay_dec_pkg.sv
package relay_dec_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] LOW_UB3    = 8'h2A;
    localparam logic [BYTE_W-1:0] LOW_UB2    = 8'h2B;
    localparam logic [BYTE_W-1:0] LOW_UB1    = 8'h2C;
    localparam logic [BYTE_W-1:0] LOW_SPARE  = 8'h2D;
    localparam logic [BYTE_W-1:0] LOW_ID     = 8'h00;
    localparam logic [BYTE_W-1:0] LOW_HWVER  = 8'h12;
    localparam logic [BYTE_W-1:0] LOW_FWVER  = 8'h13;
    localparam logic [BYTE_W-1:0] LOW_PORTAL = 8'h3F;

    typedef struct packed {
        logic              busy;
        logic              start;
        logic              rsp_v;
        logic [BYTE_W-1:0] rsp_d;
        logic              rsp_e;
        logic              wr;
        logic [BYTE_W-1:0] low;
        logic [BYTE_W-1:0] wd;
    } ctl_t;

    function automatic logic is_reserved(input logic [BYTE_W-1:0] a);
        return (a == LOW_UB3) || (a == LOW_UB2) || (a == LOW_UB1) || (a == LOW_SPARE);
    endfunction

endpackage

// File: rtl/relay_upper_regs.sv
module relay_upper_regs
    import relay_dec_pkg::*;
#(
    parameter int NUM_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BYTES-1:0]        ld_sel,
    input  logic [BYTE_W-1:0]           ld_byte,
    output logic [NUM_BYTES*BYTE_W-1:0] upper,
    output logic                        upper_zero
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] b_d, b_q;

        always_comb begin
            b_d = b_q;
            if (ld_sel[g]) b_d = ld_byte;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        assign upper[g*BYTE_W +: BYTE_W] = b_q;
    end

    assign upper_zero = ~|upper;

endmodule

// File: rtl/relay_local_resp.sv
module relay_local_resp
    import relay_dec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] HW_ID  = 8'd87,
    parameter logic [BYTE_W-1:0] HW_VER = 8'd3,
    parameter logic [BYTE_W-1:0] FW_VER = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] low,
    input  logic              upper_zero,
    input  logic              step,
    output logic              hit,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] ramp_d, ramp_q;

    always_comb begin
        hit   = 1'b0;
        rdata = '0;
        if (upper_zero) begin
            unique case (low)
                LOW_ID:     begin hit = 1'b1; rdata = HW_ID;  end
                LOW_HWVER:  begin hit = 1'b1; rdata = HW_VER; end
                LOW_FWVER:  begin hit = 1'b1; rdata = FW_VER; end
                LOW_PORTAL: begin hit = 1'b1; rdata = ramp_q; end
                default:    begin hit = 1'b0; rdata = '0;     end
            endcase
        end
    end

    always_comb begin
        ramp_d = ramp_q;
        if (step) ramp_d = ramp_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ramp_q <= '0;
        else        ramp_q <= ramp_d;
    end

endmodule

// File: rtl/relay_cmd_decoder.sv
module relay_cmd_decoder
    import relay_dec_pkg::*;
#(
    parameter int                NUM_UPPER = 3,
    parameter logic [BYTE_W-1:0] HW_ID     = 8'd87,
    parameter logic [BYTE_W-1:0] HW_VER    = 8'd3,
    parameter logic [BYTE_W-1:0] FW_VER    = 8'd4,
    localparam int               AW        = BYTE_W * (NUM_UPPER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_wdata,
    output logic              cmd_busy,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              eng_start,
    output logic              eng_write,
    output logic [AW-1:0]     eng_addr,
    output logic [BYTE_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_rdata,
    input  logic              eng_berr
);

    ctl_t s_d, s_q;

    logic                        accept;
    logic                        icpt;
    logic                        local_rd;
    logic                        loc_hit;
    logic [BYTE_W-1:0]           loc_rdata;
    logic                        ramp_step;
    logic [NUM_UPPER-1:0]        ld_sel;
    logic [NUM_UPPER*BYTE_W-1:0] upper;
    logic                        upper_zero;

    assign accept    = cmd_valid & ~s_q.busy;
    assign icpt      = cmd_write & is_reserved(cmd_addr);
    assign local_rd  = ~cmd_write & loc_hit;
    assign ramp_step = accept & local_rd & (cmd_addr == LOW_PORTAL);

    // Byte index g+1 of the bus address is loaded from reserved address 0x2C - g.
    for (genvar g = 0; g < NUM_UPPER; g++) begin : g_sel
        assign ld_sel[g] = accept & cmd_write & (cmd_addr == LOW_UB1 - BYTE_W'(g));
    end

    relay_upper_regs #(
        .NUM_BYTES (NUM_UPPER)
    ) upper_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_sel     (ld_sel),
        .ld_byte    (cmd_wdata),
        .upper      (upper),
        .upper_zero (upper_zero)
    );

    relay_local_resp #(
        .HW_ID  (HW_ID),
        .HW_VER (HW_VER),
        .FW_VER (FW_VER)
    ) local_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .low        (cmd_addr),
        .upper_zero (upper_zero),
        .step       (ramp_step),
        .hit        (loc_hit),
        .rdata      (loc_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.rsp_v = 1'b0;
        if (s_q.busy) begin
            if (eng_done) begin
                s_d.busy  = 1'b0;
                s_d.rsp_v = 1'b1;
                s_d.rsp_d = eng_rdata;
                s_d.rsp_e = eng_berr;
            end
        end else if (accept) begin
            if (icpt) begin
                s_d.rsp_v = 1'b1;
                s_d.rsp_d = '0;
                s_d.rsp_e = 1'b0;
            end else if (local_rd) begin
                s_d.rsp_v = 1'b1;
                s_d.rsp_d = loc_rdata;
                s_d.rsp_e = 1'b0;
            end else begin
                s_d.busy  = 1'b1;
                s_d.start = 1'b1;
                s_d.wr    = cmd_write;
                s_d.low   = cmd_addr;
                s_d.wd    = cmd_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_busy  = s_q.busy;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_rdata = s_q.rsp_d;
    assign rsp_err   = s_q.rsp_e;
    assign eng_start = s_q.start;
    assign eng_write = s_q.wr;
    assign eng_addr  = {upper, s_q.low};
    assign eng_wdata = s_q.wd;

endmodule

// File: rtl/relay_cmd_decoder_chk.sv
module relay_cmd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_write,
    input logic [7:0]  cmd_addr,
    input logic        cmd_busy,
    input logic        rsp_valid,
    input logic [7:0]  rsp_rdata,
    input logic        rsp_err,
    input logic        eng_start,
    input logic        eng_write,
    input logic [31:0] eng_addr,
    input logic        eng_done,
    input logic [7:0]  eng_rdata,
    input logic        eng_berr
);

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> cmd_busy);

    // R8
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !eng_start);

    // R2
    reserved_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_busy && cmd_write && cmd_addr >= 8'h2A && cmd_addr <= 8'h2D)
        |=> (!eng_start && rsp_valid && !rsp_err));

    // R2
    no_reserved_bus_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !(eng_write && eng_addr[7:0] >= 8'h2A && eng_addr[7:0] <= 8'h2D));

    // R9
    done_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && eng_done) |=>
        (rsp_valid && !cmd_busy && rsp_rdata == $past(eng_rdata) && rsp_err == $past(eng_berr)));

    // R8
    rsp_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_busy);

endmodule

bind relay_cmd_decoder relay_cmd_decoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_busy  (cmd_busy),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .eng_start (eng_start),
    .eng_write (eng_write),
    .eng_addr  (eng_addr),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata),
    .eng_berr  (eng_berr)
);

// File: tb/relay_cmd_decoder_tb_top.sv
module relay_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_busy, rsp_valid, rsp_err, eng_start, eng_write;
    logic [7:0]  rsp_rdata, eng_wdata;
    logic [31:0] eng_addr;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic        eng_berr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    relay_cmd_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_busy  (cmd_busy),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .eng_start (eng_start),
        .eng_write (eng_write),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata),
        .eng_berr  (eng_berr)
    );

    // {req[3:0], wr, addr[7:0], wdata[7:0], fwd, rdata[7:0], bus_addr[31:0]}
    localparam int NV = 21;
    localparam logic [61:0] VEC [0:NV-1] = '{
        {4'd3, 1'b0, 8'h00, 8'h00, 1'b0, 8'd87, 32'h0},         // R3 id
        {4'd3, 1'b0, 8'h12, 8'h00, 1'b0, 8'd3,  32'h0},         // R3 hw version
        {4'd3, 1'b0, 8'h13, 8'h00, 1'b0, 8'd4,  32'h0},         // R3 fw version
        {4'd4, 1'b0, 8'h3F, 8'h00, 1'b0, 8'd0,  32'h0},         // R4 ramp 0
        {4'd4, 1'b0, 8'h3F, 8'h00, 1'b0, 8'd1,  32'h0},         // R4 ramp 1
        {4'd7, 1'b0, 8'h05, 8'h00, 1'b1, 8'd0,  32'h00000005},  // R7 unmapped read
        {4'd1, 1'b1, 8'h2C, 8'h12, 1'b0, 8'd0,  32'h0},         // R1 byte1
        {4'd1, 1'b1, 8'h2B, 8'h34, 1'b0, 8'd0,  32'h0},         // R1 byte2
        {4'd1, 1'b1, 8'h2A, 8'h56, 1'b0, 8'd0,  32'h0},         // R1 byte3
        {4'd2, 1'b1, 8'h2D, 8'h99, 1'b0, 8'd0,  32'h0},         // R2 swallowed
        {4'd5, 1'b1, 8'h40, 8'hA5, 1'b1, 8'd0,  32'h56341240},  // R5 forwarded write
        {4'd6, 1'b0, 8'h00, 8'h00, 1'b1, 8'd0,  32'h56341200},  // R6 id forwarded
        {4'd6, 1'b0, 8'h3F, 8'h00, 1'b1, 8'd0,  32'h5634123F},  // R6 portal forwarded
        {4'd1, 1'b1, 8'h2A, 8'h00, 1'b0, 8'd0,  32'h0},         // R1
        {4'd1, 1'b1, 8'h2B, 8'h00, 1'b0, 8'd0,  32'h0},         // R1
        {4'd6, 1'b0, 8'h13, 8'h00, 1'b1, 8'd0,  32'h00001213},  // R6 byte1 alone
        {4'd1, 1'b1, 8'h2C, 8'h00, 1'b0, 8'd0,  32'h0},         // R1
        {4'd4, 1'b0, 8'h3F, 8'h00, 1'b0, 8'd2,  32'h0},         // R4 ramp kept
        {4'd1, 1'b1, 8'h2A, 8'h01, 1'b0, 8'd0,  32'h0},         // R1
        {4'd6, 1'b0, 8'h00, 8'h00, 1'b1, 8'd0,  32'h01000000},  // R6 byte3 alone
        {4'd1, 1'b1, 8'h2A, 8'h00, 1'b0, 8'd0,  32'h0}          // R1
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Engine answers a pending request after a short delay.
    task automatic engine_reply(input logic [7:0] rd, input logic berr, input string req);
        @(negedge clk);
        check(eng_start == 1'b0, "R5", "start width", 32'(eng_start), 32'd0);
        check(cmd_busy == 1'b1, "R8", "busy held", 32'(cmd_busy), 32'd1);
        eng_done  = 1'b1;
        eng_rdata = rd;
        eng_berr  = berr;
        @(negedge clk);
        eng_done  = 1'b0;
        eng_berr  = 1'b0;
        check(rsp_valid == 1'b1, req, "rsp_valid after done", 32'(rsp_valid), 32'd1);
        check(rsp_rdata == rd, "R9", "rsp_rdata", 32'(rsp_rdata), 32'(rd));
        check(rsp_err == berr, "R9", "rsp_err", 32'(rsp_err), 32'(berr));
        check(cmd_busy == 1'b0, "R9", "busy cleared", 32'(cmd_busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cmd_busy == 1'b0 && rsp_valid == 1'b0 && eng_start == 1'b0, "R10",
              "outputs in reset", {29'd0, cmd_busy, rsp_valid, eng_start}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            automatic logic [61:0] v   = VEC[i];
            automatic string       req = $sformatf("R%0d", v[61:58]);
            automatic logic [7:0]  a   = v[56:49];
            issue(v[57], a, v[48:41]);
            if (v[40]) begin
                check(eng_start == 1'b1, req, $sformatf("row %0d start", i), 32'(eng_start), 32'd1);
                check(eng_addr == v[31:0], req, $sformatf("row %0d addr", i), eng_addr, v[31:0]);
                check(eng_write == v[57], "R5", "eng_write", 32'(eng_write), 32'(v[57]));
                if (v[57]) check(eng_wdata == v[48:41], "R5", "eng_wdata", 32'(eng_wdata), 32'(v[48:41]));
                check(rsp_valid == 1'b0, req, "no early response", 32'(rsp_valid), 32'd0);
                engine_reply(a ^ 8'hC3, 1'b0, req);
            end else begin
                check(eng_start == 1'b0, req, $sformatf("row %0d no start", i), 32'(eng_start), 32'd0);
                check(rsp_valid == 1'b1, req, $sformatf("row %0d rsp_valid", i), 32'(rsp_valid), 32'd1);
                check(rsp_rdata == v[39:32], req, $sformatf("row %0d rdata", i), 32'(rsp_rdata), 32'(v[39:32]));
                check(rsp_err == 1'b0, req, "local rsp_err", 32'(rsp_err), 32'd0);
            end
        end

        // R4: ramp runs on from 3 and wraps through 255 to 0
        for (int k = 3; k < 260; k++) begin
            issue(1'b0, 8'h3F, 8'h00);
            check(rsp_rdata == 8'(k), "R4", "ramp value", 32'(rsp_rdata), 32'(8'(k)));
        end

        // R8: a base write while busy is ignored
        issue(1'b0, 8'h07, 8'h00);
        check(eng_addr == 32'h00000007, "R7", "forward addr", eng_addr, 32'h00000007);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h2A; cmd_wdata = 8'h77;
        repeat (3) begin
            @(negedge clk);
            check(eng_start == 1'b0 && rsp_valid == 1'b0, "R8", "ignored while busy",
                  {30'd0, eng_start, rsp_valid}, 32'd0);
        end
        cmd_valid = 1'b0;
        engine_reply(8'h5A, 1'b0, "R8");
        issue(1'b0, 8'h00, 8'h00);
        check(rsp_valid == 1'b1 && rsp_rdata == 8'd87, "R8", "byte3 unchanged after busy write",
              {23'd0, rsp_valid, rsp_rdata}, {23'd0, 1'b1, 8'd87});

        // R9: bus error is reported
        issue(1'b1, 8'h10, 8'h3C);
        check(eng_start == 1'b1, "R9", "start", 32'(eng_start), 32'd1);
        engine_reply(8'hE1, 1'b1, "R9");

        // R2: write to 0x2D leaves the upper bytes at zero
        issue(1'b1, 8'h2D, 8'hFF);
        check(eng_start == 1'b0, "R2", "no start", 32'(eng_start), 32'd0);
        issue(1'b0, 8'h12, 8'h00);
        check(rsp_valid == 1'b1 && rsp_rdata == 8'd3, "R2", "base still zero",
              {23'd0, rsp_valid, rsp_rdata}, {23'd0, 1'b1, 8'd3});

        // R10: reset in mid-run clears the upper bytes and the ramp
        issue(1'b1, 8'h2B, 8'hAB);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        issue(1'b0, 8'h3F, 8'h00);
        check(rsp_valid == 1'b1 && rsp_rdata == 8'd0, "R10", "ramp and base after reset",
              {23'd0, rsp_valid, rsp_rdata}, {23'd0, 1'b1, 8'd0});
        issue(1'b0, 8'h05, 8'h00);
        check(eng_addr == 32'h00000005, "R10", "upper bytes after reset", eng_addr, 32'h00000005);
        engine_reply(8'h11, 1'b0, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule